// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block converts a 48-bit virtual address into a 52-bit physical address. It does this by reading a chain of four 64-bit translation entries from memory. The walk starts at a 40-bit root frame number, which the surrounding context supplies with each process. At each level, nine bits of the virtual address select an entry inside the current table. If that entry is valid, its frame field names the next table, or at the last level the page itself. The low twelve bits of the address pass through unchanged.

Each entry fetched is checked against the access that is being translated: a read or a write, supervisor or user mode, and a data access or an instruction fetch. The first entry that refuses the access ends the walk with a fault code. Entries that allow the access get their accessed bit set, and on a write the last-level entry also gets its dirty bit set. The updated entry is written back to the same address before the walk moves on, but only when a bit has actually changed.

Requests use a valid/ready handshake. Memory is reached through a single port that has at most one read outstanding; writes on that port complete at their handshake. The result appears on a one-cycle completion strobe.

Top module: `page_walker`

## Requirements
- R1: Entry address. The first read of a walk goes to {root_base, idx0, 3'b000}. Each later read goes to {frame of previous entry (bits 51:12), idxN, 3'b000}. The virtual address splits as idx0 = va[47:39], idx1 = va[38:30], idx2 = va[29:21], idx3 = va[20:12].
- R2: A walk without a fault returns rsp_paddr = {last entry bits 51:12, va[11:0]} with rsp_fault = 0.
- R3: An entry with bit 0 (present) clear, at any level, ends the walk with rsp_fault = 1 and rsp_fault_type = 0.
- R4: A write through an entry whose bit 1 (writable) is clear ends the walk with rsp_fault_type = 1.
- R5: A user-mode access through an entry whose bit 2 (user allowed) is clear ends the walk with rsp_fault_type = 2.
- R6: An instruction fetch through an entry whose bit 63 (no-execute) is set ends the walk with rsp_fault_type = 3. Within one entry the checks rank as follows: not-present, then write, then user, then fetch.
- R7: Every entry that passes its check is written back with bit 5 (accessed) set. No write happens when the entry already holds the value it would be written with.
- R8: Bit 6 (dirty) is set only in the last-level entry, and only when the access is a write. A read leaves it clear.
- R9: req_ready is high only while the block is idle. rsp_done is a one-cycle pulse. A memory request is held stable until it is accepted, and no new request is raised while a read is outstanding.
- R10: The entry that causes a fault is never written back. The walk ends directly after that entry is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 40 | Frame number of the top-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| req_exec | input | 1 | Access is an instruction fetch |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write back an entry, 0 = read an entry |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_req_wdata | output | 64 | Updated entry for a write |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_fault | output | 1 | The walk ended in a fault |
| rsp_fault_type | output | 2 | 0 not present, 1 write, 2 user, 3 fetch |
| rsp_paddr | output | 52 | Translated physical address |

## Verification
The bench builds the walker with its default parameters: four levels, 9-bit indices and a 12-bit offset. With these values the bench can place a fault at the top, middle and last levels, and it can use the top index extremes 0, 254 and 511. Several pages share upper tables, so the count of write-backs per walk moves between four, two, one and zero as the accessed bits fill in. The behavioural memory alternates between zero and one extra cycle of read latency, so the wait state is exercised under both timings.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int PTE_W    = 64;
    localparam int BASE_W   = 40;
    localparam int BASE_LSB = 12;

    localparam int B_PRESENT = 0;
    localparam int B_RW      = 1;
    localparam int B_US      = 2;
    localparam int B_ACC     = 5;
    localparam int B_DIRTY   = 6;
    localparam int B_XD      = 63;

    typedef enum logic [1:0] {
        FT_NOTPRES = 2'd0,
        FT_WRITE   = 2'd1,
        FT_USER    = 2'd2,
        FT_EXEC    = 2'd3
    } fault_e;

    typedef struct packed {
        logic wr;
        logic user;
        logic exec;
    } access_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_REQ,
        S_RD_WAIT,
        S_WR_REQ,
        S_DONE
    } state_e;

    function automatic logic [BASE_W-1:0] pte_frame(input logic [PTE_W-1:0] e);
        return e[BASE_LSB +: BASE_W];
    endfunction

endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
    import pw_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    localparam int VA_W  = LEVELS * IDX_W + OFF_W,
    localparam int PA_W  = BASE_W + OFF_W,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int ENT_B = $clog2(PTE_W / 8)
) (
    input  logic [BASE_W-1:0] base,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [LVL_W-1:0]  level,
    output logic [PA_W-1:0]   ent_addr
);

    logic [IDX_W-1:0] idx_tbl [LEVELS];

    // Level 0 takes the most significant index field.
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_tbl[g] = vaddr[OFF_W + IDX_W * (LEVELS - 1 - g) +: IDX_W];
    end

    assign ent_addr = {base, idx_tbl[level], {ENT_B{1'b0}}};

endmodule

// File: rtl/pw_entry_check.sv
module pw_entry_check
    import pw_pkg::*;
(
    input  logic [PTE_W-1:0] entry,
    input  logic             is_leaf,
    input  access_t          acc,
    output logic             fault,
    output fault_e           ftype,
    output logic [PTE_W-1:0] upd_entry,
    output logic             need_wb
);

    always_comb begin
        fault = 1'b1;
        ftype = FT_NOTPRES;
        if (!entry[B_PRESENT]) begin
            ftype = FT_NOTPRES;
        end else if (acc.wr && !entry[B_RW]) begin
            ftype = FT_WRITE;
        end else if (acc.user && !entry[B_US]) begin
            ftype = FT_USER;
        end else if (acc.exec && entry[B_XD]) begin
            ftype = FT_EXEC;
        end else begin
            fault = 1'b0;
        end
    end

    always_comb begin
        upd_entry        = entry;
        upd_entry[B_ACC] = 1'b1;
        if (is_leaf && acc.wr) begin
            upd_entry[B_DIRTY] = 1'b1;
        end
        need_wb = !fault && (upd_entry != entry);
    end

endmodule

// File: rtl/page_walker.sv
module page_walker
    import pw_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    localparam int VA_W  = LEVELS * IDX_W + OFF_W,
    localparam int PA_W  = BASE_W + OFF_W,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BASE_W-1:0] root_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              req_exec,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic [PTE_W-1:0]  mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              rsp_done,
    output logic              rsp_fault,
    output logic [1:0]        rsp_fault_type,
    output logic [PA_W-1:0]   rsp_paddr
);

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    state_e            state;
    logic [VA_W-1:0]   va_q;
    access_t           acc_q;
    logic [LVL_W-1:0]  level_q;
    logic [BASE_W-1:0] base_q;
    logic [PTE_W-1:0]  ent_q;
    logic              fault_q;
    fault_e            ftype_q;
    logic [PA_W-1:0]   paddr_q;

    logic              chk_fault;
    fault_e            chk_ftype;
    logic [PTE_W-1:0]  chk_upd;
    logic              chk_wb;
    logic              adv_go;
    logic [PTE_W-1:0]  adv_ent;

    pw_addr_gen #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W)
    ) u_addr (
        .base     (base_q),
        .vaddr    (va_q),
        .level    (level_q),
        .ent_addr (mem_req_addr)
    );

    pw_entry_check u_chk (
        .entry     (mem_rsp_data),
        .is_leaf   (level_q == LAST_LVL),
        .acc       (acc_q),
        .fault     (chk_fault),
        .ftype     (chk_ftype),
        .upd_entry (chk_upd),
        .need_wb   (chk_wb)
    );

    assign req_ready      = (state == S_IDLE);
    assign mem_req_valid  = (state == S_RD_REQ) || (state == S_WR_REQ);
    assign mem_req_write  = (state == S_WR_REQ);
    assign mem_req_wdata  = ent_q;
    assign rsp_done       = (state == S_DONE);
    assign rsp_fault      = fault_q;
    assign rsp_fault_type = ftype_q;
    assign rsp_paddr      = paddr_q;

    // Move to the next level, or finish, once an entry is settled.
    always_comb begin
        adv_ent = (state == S_WR_REQ) ? ent_q : mem_rsp_data;
        adv_go  = ((state == S_RD_WAIT) && mem_rsp_valid && !chk_fault && !chk_wb)
               || ((state == S_WR_REQ) && mem_req_ready);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            va_q    <= '0;
            acc_q   <= '0;
            level_q <= '0;
            base_q  <= '0;
            ent_q   <= '0;
            fault_q <= 1'b0;
            ftype_q <= FT_NOTPRES;
            paddr_q <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        acc_q   <= '{wr: req_write, user: req_user, exec: req_exec};
                        base_q  <= root_base;
                        level_q <= '0;
                        fault_q <= 1'b0;
                        ftype_q <= FT_NOTPRES;
                        state   <= S_RD_REQ;
                    end
                end
                S_RD_REQ: begin
                    if (mem_req_ready) state <= S_RD_WAIT;
                end
                S_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (chk_fault) begin
                            fault_q <= 1'b1;
                            ftype_q <= chk_ftype;
                            state   <= S_DONE;
                        end else if (chk_wb) begin
                            ent_q <= chk_upd;
                            state <= S_WR_REQ;
                        end
                    end
                end
                S_DONE: state <= S_IDLE;
                default: ;
            endcase
            if (adv_go) begin
                if (level_q == LAST_LVL) begin
                    paddr_q <= {pte_frame(adv_ent), va_q[OFF_W-1:0]};
                    state   <= S_DONE;
                end else begin
                    base_q  <= pte_frame(adv_ent);
                    level_q <= level_q + LVL_W'(1);
                    state   <= S_RD_REQ;
                end
            end
        end
    end

    a_r1_root_first: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (mem_req_addr[PA_W-1:OFF_W] == $past(root_base)));

    a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

    a_r7_wb_accessed: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[B_ACC]);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> (!rsp_done && req_ready));

    a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r9_no_req_in_wait: assert property (@(posedge clk) disable iff (rst)
        (state == S_RD_WAIT) |-> !mem_req_valid);

    a_r10_fault_after_read: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_fault) |-> ($past(state) == S_RD_WAIT));

endmodule

// File: tb/tb_page_walker.sv
`timescale 1ns/1ps
module tb_page_walker;

    localparam logic [39:0] ROOT = 40'h00010;
    localparam logic [63:0] F_P  = 64'h1;
    localparam logic [63:0] F_RW = 64'h2;
    localparam logic [63:0] F_US = 64'h4;
    localparam logic [63:0] F_A  = 64'h20;
    localparam logic [63:0] F_D  = 64'h40;
    localparam logic [63:0] F_XD = 64'h8000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        req_exec = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_write;
    logic [51:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_done;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_type;
    logic [51:0] rsp_paddr;

    always #2.5 clk = ~clk;

    page_walker dut (
        .clk(clk), .rst(rst), .root_base(ROOT),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user), .req_exec(req_exec),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
        .rsp_fault_type(rsp_fault_type), .rsp_paddr(rsp_paddr)
    );

    logic [63:0] mem [logic [51:0]];
    logic [39:0] next_frame = 40'h00100;
    int          n_chk = 0;
    int          n_fail = 0;
    int          wr_cnt = 0;
    bit          slow = 1'b0;

    typedef struct {
        logic        fault;
        logic [1:0]  ft;
        logic [51:0] pa;
        int          nwr;
        string       tag;
    } exp_t;
    exp_t sb[$];

    function automatic logic [63:0] rd(input logic [51:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    function automatic logic [51:0] ent_addr(input logic [39:0] base,
                                             input logic [47:0] va, input int lvl);
        logic [8:0] idx;
        idx = va[47 - 9*lvl -: 9];
        return {base, idx, 3'b000};
    endfunction

    function automatic logic [51:0] leaf_addr(input logic [47:0] va);
        logic [39:0] b;
        b = ROOT;
        for (int l = 0; l < 3; l++) b = rd(ent_addr(b, va, l))[51:12];
        return ent_addr(b, va, 3);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic map_page(input logic [47:0] va, input logic [39:0] ppn,
                            input logic [63:0] leaf_fl, input logic [63:0] inner_fl);
        logic [39:0] b;
        logic [51:0] a;
        b = ROOT;
        for (int l = 0; l < 3; l++) begin
            a = ent_addr(b, va, l);
            if (!rd(a)[0]) begin
                mem[a] = {12'h0, next_frame, 12'h0} | inner_fl;
                next_frame++;
            end
            b = mem[a][51:12];
        end
        mem[ent_addr(b, va, 3)] = {12'h0, ppn, 12'h0} | leaf_fl;
    endtask

    // Reference walk over the bench memory, computed before the request.
    task automatic walk(input logic [47:0] va, input bit wr, input bit us, input bit ex,
                        input string tag);
        exp_t        e;
        logic [39:0] b;
        logic [63:0] p, u;
        e.fault = 1'b0; e.ft = 2'd0; e.nwr = 0; e.tag = tag; e.pa = '0;
        b = ROOT;
        for (int l = 0; l < 4; l++) begin
            p = rd(ent_addr(b, va, l));
            if (!p[0])                 begin e.fault = 1; e.ft = 2'd0; break; end
            else if (wr && !p[1])      begin e.fault = 1; e.ft = 2'd1; break; end
            else if (us && !p[2])      begin e.fault = 1; e.ft = 2'd2; break; end
            else if (ex && p[63])      begin e.fault = 1; e.ft = 2'd3; break; end
            u = p | F_A;
            if (l == 3 && wr) u = u | F_D;
            if (u != p) e.nwr++;
            b = p[51:12];
        end
        if (!e.fault) e.pa = {b, va[11:0]};
        sb.push_back(e);
        @(posedge clk); #1;
        wr_cnt = 0;
        req_vaddr = va; req_write = wr; req_user = us; req_exec = ex;
        req_valid = 1'b1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
        @(negedge clk);
        chk({tag, " R9 busy during walk"}, 64'(req_ready), 64'h0);
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Behavioural memory: always ready, read latency alternates.
    initial begin
        logic        v, w;
        logic [51:0] a;
        logic [63:0] d;
        forever begin
            @(negedge clk);
            v = mem_req_valid; w = mem_req_write; a = mem_req_addr; d = mem_req_wdata;
            @(posedge clk); #1;
            mem_rsp_valid = 1'b0;
            if (v && !rst) begin
                if (w) begin
                    mem[a] = d;
                    wr_cnt++;
                end else begin
                    if (slow) begin
                        @(posedge clk); #1;
                    end
                    slow = ~slow;
                    mem_rsp_data  = rd(a);
                    mem_rsp_valid = 1'b1;
                end
            end
        end
    end

    // Monitor: compares each completion against the scoreboard head.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rsp_done === 1'b1) begin
                if (sb.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R9 unexpected completion actual=1 expected=0");
                end else begin
                    e = sb.pop_front();
                    chk({e.tag, " R3-6 fault flag"}, 64'(rsp_fault), 64'(e.fault));
                    if (e.fault) chk({e.tag, " fault code"}, 64'(rsp_fault_type), 64'(e.ft));
                    else         chk({e.tag, " R2 paddr"}, 64'(rsp_paddr), 64'(e.pa));
                    chk({e.tag, " R7 write-back count"}, 64'(wr_cnt), 64'(e.nwr));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] saved;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R9 reset ready", 64'(req_ready), 64'h1);
        chk("R9 reset done", 64'(rsp_done), 64'h0);
        chk("R9 reset mem idle", 64'(mem_req_valid), 64'h0);

        map_page(48'h0000_1234_5678, 40'hABCDE, F_P | F_RW | F_US, F_P | F_RW | F_US);
        walk(48'h0000_1234_5678, 0, 1, 0, "R1 R7 first user read");
        chk("R7 leaf accessed", 64'(rd(leaf_addr(48'h0000_1234_5678))[5]), 64'h1);
        chk("R8 leaf clean after read", 64'(rd(leaf_addr(48'h0000_1234_5678))[6]), 64'h0);
        walk(48'h0000_1234_5678, 0, 1, 0, "R7 repeat read no writes");
        walk(48'h0000_1234_5678, 1, 0, 0, "R8 write sets dirty");
        chk("R8 leaf dirty", 64'(rd(leaf_addr(48'h0000_1234_5678))[6]), 64'h1);

        map_page(48'h0000_1234_6678, 40'h55555, F_P | F_RW | F_US, F_P | F_RW | F_US);
        walk(48'h0000_1234_6678, 0, 0, 0, "R7 sibling leaf only");
        chk("R8 sibling clean", 64'(rd(leaf_addr(48'h0000_1234_6678))[6]), 64'h0);

        walk(48'h0000_1254_5678, 0, 0, 0, "R3 absent at level 2");
        walk(48'h8000_0000_0000, 0, 0, 0, "R3 absent at level 0");

        map_page(48'h0000_4000_0000, 40'h11111, F_P | F_US, F_P | F_RW | F_US);
        saved = rd(leaf_addr(48'h0000_4000_0000));
        walk(48'h0000_4000_0000, 1, 1, 0, "R4 write to read-only");
        chk("R10 faulting leaf unchanged", rd(leaf_addr(48'h0000_4000_0000)), saved);

        map_page(48'h0000_8000_0000, 40'h22222, F_P | F_RW | F_US | F_XD, F_P | F_RW | F_US);
        walk(48'h0000_8000_0000, 0, 0, 1, "R6 fetch from no-execute");
        walk(48'h0000_8000_0000, 0, 0, 0, "R2 data read no-execute page");

        map_page(48'h7F00_0000_0000, 40'h33333, F_P | F_RW | F_US, F_P | F_RW);
        walk(48'h7F00_0000_0000, 0, 1, 0, "R5 user through supervisor table");
        walk(48'h7F00_0000_0000, 0, 0, 0, "R5 supervisor passes");

        map_page(48'h0000_C000_0000, 40'h44444, F_P | F_XD, F_P | F_RW | F_US);
        walk(48'h0000_C000_0000, 1, 1, 1, "R6 priority write first");
        walk(48'h0000_C000_0000, 0, 1, 1, "R6 priority user before fetch");

        map_page(48'hFFFF_FFFF_F123, 40'hFEDCB, F_P | F_RW | F_US, F_P | F_RW | F_US);
        walk(48'hFFFF_FFFF_F123, 1, 1, 0, "R1 top index fields");
        chk("R1 paddr value", 64'(rsp_paddr), 64'h0_00FE_DCB1_23);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule